// File: doc/BRIEF.md
# Lane Link Establishment Receiver

This block runs the receive side of link start-up for a single lane of a multi-lane converter link. Each clock it takes one decoded octet together with a flag that marks the octet as a control character. It drives the active-low synchronization request back to the transmitter. While that request is low, the transmitter repeats a fixed control character. Once enough of them arrive in a row, the receiver releases the request.

The transmitter then sends an alignment sequence of four multiframes. The sequence has to start on a multiframe boundary, which an external pulse marks. Each multiframe of the sequence opens with a start marker and closes with an end marker. The second multiframe also carries link configuration octets, and the block keeps them in a register bank.

If the sequence is broken, the block flags an error and asks for synchronization again. When the fourth multiframe ends cleanly, the block passes the octets that follow to its output as valid user data. The frame length and the multiframe length are parameters. Deserialization, line decoding, descrambling and deskew across lanes are done elsewhere.

Top module: `lane_link_rx`

## Requirements
- R1: After reset, `sync_n` is 0 and `ilas_active`, `data_valid`, `cfg_valid` and `align_err` are all 0.
- R2: A character counts only when `rx_is_ctrl` is 1. The values are 0xBC for the sync character, 0x1C for the multiframe start marker, 0x7C for the multiframe end marker and 0x9C for the configuration marker. The same byte arriving with `rx_is_ctrl` 0 is data.
- R3: `sync_n` goes to 1 at the clock edge that samples the fourth consecutive sync character.
- R4: Any other octet before that fourth sync character restarts the count, and `sync_n` stays 0.
- R5: After release, sync characters keep the block waiting. A start marker sampled with `mf_boundary` at 1 starts the alignment sequence, and `ilas_active` is 1 after that edge. A start marker without the boundary, or any other octet, is a fault.
- R6: The octets at positions 2 through MF_LEN-2 of the second multiframe (position 0 is its start marker) are stored in `cfg_bank`. Position 2 goes to bits [7:0], and each later position goes to the next byte up. `cfg_valid` goes to 1 at the edge that samples the end marker of that multiframe.
- R7: Position 1 of the second multiframe must be the configuration marker, otherwise a fault occurs.
- R8: The last position (MF_LEN-1) of every multiframe in the sequence must be the end marker, otherwise a fault occurs. A fault sets `align_err` to 1 and `sync_n` to 0, clears `ilas_active` and `cfg_valid`, and restarts the search for sync characters.
- R9: `data_valid` stays 0 through the end marker of the fourth multiframe. From the next octet on, each sampled octet appears on `data_out` with `data_valid` 1 after the edge that samples it.
- R10: `align_err` stays at 1 until the next successful lock, and it clears at the edge where `sync_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_octet | input | 8 | Decoded octet |
| rx_is_ctrl | input | 1 | 1 when the octet is a control character |
| mf_boundary | input | 1 | Pulse that marks the first octet of a local multiframe |
| sync_n | output | 1 | Synchronization request to the transmitter, active low |
| ilas_active | output | 1 | Alignment sequence in progress |
| data_valid | output | 1 | `data_out` holds user data |
| data_out | output | 8 | User data octet |
| cfg_valid | output | 1 | `cfg_bank` holds a complete configuration |
| cfg_bank | output | CFG_LEN*8 (40) | Captured configuration octets, first octet in the low byte |
| align_err | output | 1 | Sticky flag for a broken alignment sequence |

## Verification
Every output is a register that updates at the same edge that samples the octet causing the change. So `sync_n`, `ilas_active`, `cfg_valid`, `align_err`, `data_valid` and `data_out` each show the effect of an octet one edge after it is driven. The bench drives each octet on a falling edge and reads the outputs 1 ns after the following rising edge, so every check compares against the octet just sent. `cfg_bank` is read right after the second multiframe's end marker. `data_valid` is checked to be 0 after each octet of the last multiframe, and then again after the first data octet that follows it.

// File: rtl/lane_link_pkg.sv
// Package: shared character codes, state type and decoded-character flags
// for the lane link establishment receiver.
package lane_link_pkg;

    localparam logic [7:0] CH_SYNC = 8'hBC;
    localparam logic [7:0] CH_MSTART = 8'h1C;
    localparam logic [7:0] CH_MEND = 8'h7C;
    localparam logic [7:0] CH_CFGMK = 8'h9C;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_WAIT = 2'd1,
        ST_ALIGN = 2'd2,
        ST_DATA = 2'd3
    } link_state_t;

    typedef struct packed {
        logic sync_ch;
        logic mstart;
        logic mend;
        logic cfgmk;
    } char_flags_t;

endpackage

// File: rtl/char_classify.sv
// char_classify: turns one octet and its control flag into one flag per
// link character. Assumes: a character counts only when the control flag
// is set; a data octet with the same byte value never matches.
module char_classify
    import lane_link_pkg::*;
(
    input  logic [7:0]  octet,
    input  logic        is_ctrl,
    output char_flags_t flags
);

    // Compare the byte against each code, gated by the control flag.
    always_comb begin
        flags.sync_ch = is_ctrl && (octet == CH_SYNC);
        flags.mstart = is_ctrl && (octet == CH_MSTART);
        flags.mend = is_ctrl && (octet == CH_MEND);
        flags.cfgmk = is_ctrl && (octet == CH_CFGMK);
    end

endmodule

// File: rtl/cgs_counter.sv
// cgs_counter: counts consecutive sync characters while enabled and
// reports lock on the NEED-th one. Assumes: the count restarts on any other
// octet and while disabled; the lock output is combinational on the
// sampling cycle.
module cgs_counter #(
    parameter int NEED = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic is_sync,
    output logic lock
);

    localparam int CW = $clog2(NEED + 1);

    logic [CW-1:0] cnt;

    // Lock fires when the last character of the run arrives.
    assign lock = enable && is_sync && (cnt == CW'(NEED - 1));

    // Run-length counter for consecutive sync characters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!enable || !is_sync || lock) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r4_count_below_need: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(NEED));

    a_r4_break_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !is_sync) |=> (cnt == '0));

endmodule

// File: rtl/ilas_position.sv
// ilas_position: tracks the octet position inside a multiframe and the
// multiframe number inside the alignment sequence. Assumes: start is
// raised on the cycle that samples the opening start marker (position 0
// of multiframe 0), so the next octet is at position 1.
module ilas_position #(
    parameter int MF_LEN = 8,
    parameter int MF_COUNT = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        run,
    output logic [$clog2(MF_LEN)-1:0]   oct_idx,
    output logic [$clog2(MF_COUNT)-1:0] mf_idx,
    output logic                        last_oct,
    output logic                        last_mf
);

    localparam int OW = $clog2(MF_LEN);
    localparam int MW = $clog2(MF_COUNT);

    assign last_oct = (oct_idx == OW'(MF_LEN - 1));
    assign last_mf = (mf_idx == MW'(MF_COUNT - 1));

    // Step the position each octet and roll over into the next multiframe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oct_idx <= '0;
            mf_idx <= '0;
        end else if (start) begin
            oct_idx <= OW'(1);
            mf_idx <= '0;
        end else if (run) begin
            if (last_oct) begin
                oct_idx <= '0;
                mf_idx <= mf_idx + 1'b1;
            end else begin
                oct_idx <= oct_idx + 1'b1;
            end
        end
    end

    a_r5_start_lands_on_one: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (oct_idx == OW'(1) && mf_idx == '0));

endmodule

// File: rtl/cfg_bank_store.sv
// cfg_bank_store: register bank for the configuration octets, one byte
// per slot, with slot 0 in the low byte. Assumes: the writer keeps the
// index below DEPTH; contents stay until overwritten.
module cfg_bank_store #(
    parameter int DEPTH = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [7:0]               wr_data,
    output logic [DEPTH*8-1:0]       bank
);

    localparam int IW = $clog2(DEPTH);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Slot register: loads when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank[i*8 +: 8] <= 8'h00;
            end else if (wr_en && (wr_idx == IW'(i))) begin
                bank[i*8 +: 8] <= wr_data;
            end
        end
    end

    a_r6_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_idx} < (IW + 1)'(DEPTH)));

endmodule

// File: rtl/lane_link_rx.sv
// lane_link_rx: link start-up receiver for one lane. It searches for
// sync characters, releases the request, follows the four-multiframe
// alignment sequence, captures its configuration octets and then passes
// user data. Assumes: octets are already decoded; mf_boundary marks the
// first octet of a local multiframe; MF_LEN is at least 4.
module lane_link_rx
    import lane_link_pkg::*;
#(
    parameter int FRAMES_PER_MF = 4,
    parameter int OCTETS_PER_FRAME = 2,
    parameter int SYNC_RUN = 4,
    parameter int ALIGN_MFS = 4,
    localparam int MF_LEN = FRAMES_PER_MF * OCTETS_PER_FRAME,
    localparam int CFG_LEN = MF_LEN - 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           rx_octet,
    input  logic                 rx_is_ctrl,
    input  logic                 mf_boundary,
    output logic                 sync_n,
    output logic                 ilas_active,
    output logic                 data_valid,
    output logic [7:0]           data_out,
    output logic                 cfg_valid,
    output logic [CFG_LEN*8-1:0] cfg_bank,
    output logic                 align_err
);

    localparam int OW = $clog2(MF_LEN);
    localparam int MW = $clog2(ALIGN_MFS);
    localparam int IW = $clog2(CFG_LEN);

    link_state_t state;
    char_flags_t fl;
    logic cgs_lock;
    logic seq_start;
    logic seq_fault;
    logic seq_done;
    logic cfg_done;
    logic cfg_wr;
    logic [OW-1:0] oct_idx;
    logic [MW-1:0] mf_idx;
    logic last_oct;
    logic last_mf;
    logic in_cfg_mf;

    char_classify u_cls (
        .octet   (rx_octet),
        .is_ctrl (rx_is_ctrl),
        .flags   (fl)
    );

    cgs_counter #(.NEED(SYNC_RUN)) u_cgs (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (state == ST_SEARCH),
        .is_sync (fl.sync_ch),
        .lock    (cgs_lock)
    );

    ilas_position #(.MF_LEN(MF_LEN), .MF_COUNT(ALIGN_MFS)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (seq_start),
        .run      (state == ST_ALIGN),
        .oct_idx  (oct_idx),
        .mf_idx   (mf_idx),
        .last_oct (last_oct),
        .last_mf  (last_mf)
    );

    cfg_bank_store #(.DEPTH(CFG_LEN)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_idx  (IW'(oct_idx - OW'(2))),
        .wr_data (rx_octet),
        .bank    (cfg_bank)
    );

    assign ilas_active = (state == ST_ALIGN);
    assign in_cfg_mf = (state == ST_ALIGN) && (mf_idx == MW'(1));

    // Sequence events for the current octet: start, fault, completion, capture.
    always_comb begin
        seq_start = (state == ST_WAIT) && fl.mstart && mf_boundary;
        seq_fault = 1'b0;
        seq_done = 1'b0;
        cfg_done = 1'b0;
        cfg_wr = in_cfg_mf && (oct_idx >= OW'(2)) && (oct_idx <= OW'(MF_LEN - 2));
        if (state == ST_WAIT) begin
            seq_fault = !fl.sync_ch && !seq_start;
        end else if (state == ST_ALIGN) begin
            if (in_cfg_mf && (oct_idx == OW'(1)) && !fl.cfgmk) begin
                seq_fault = 1'b1;
            end else if (last_oct) begin
                seq_fault = !fl.mend;
                seq_done = fl.mend && last_mf;
                cfg_done = fl.mend && in_cfg_mf;
            end
        end
    end

    // Link state, request line, flags and data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SEARCH;
            sync_n <= 1'b0;
            align_err <= 1'b0;
            cfg_valid <= 1'b0;
            data_valid <= 1'b0;
            data_out <= 8'h00;
        end else begin
            data_valid <= 1'b0;
            if (seq_fault) begin
                state <= ST_SEARCH;
                sync_n <= 1'b0;
                align_err <= 1'b1;
                cfg_valid <= 1'b0;
            end else begin
                case (state)
                    ST_SEARCH: begin
                        if (cgs_lock) begin
                            state <= ST_WAIT;
                            sync_n <= 1'b1;
                            align_err <= 1'b0;
                        end
                    end
                    ST_WAIT: begin
                        if (seq_start) begin
                            state <= ST_ALIGN;
                        end
                    end
                    ST_ALIGN: begin
                        if (seq_done) begin
                            state <= ST_DATA;
                        end
                        if (cfg_done) begin
                            cfg_valid <= 1'b1;
                        end
                    end
                    default: begin
                        data_valid <= 1'b1;
                        data_out <= rx_octet;
                    end
                endcase
            end
        end
    end

    a_r1_request_low_while_searching: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH) |-> !sync_n);

    a_r3_release_only_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |-> $past(cgs_lock));

    a_r8_fault_drops_link: assert property (@(posedge clk) disable iff (!rst_n)
        seq_fault |=> (!sync_n && align_err && !cfg_valid && !ilas_active));

    a_r9_no_data_before_end: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (state == ST_DATA));

    a_r6_cfg_valid_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> (state == ST_ALIGN || state == ST_DATA));

    a_r10_error_clears_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |-> !align_err);

endmodule

// File: tb/lane_link_rx_tb.sv
// Directed bench for lane_link_rx: one task per scenario, each checking
// its own results right after the edge that samples the stimulus.
module lane_link_rx_tb;

    localparam int MF = 8;
    localparam int CFGN = MF - 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] rx_octet = 8'h00;
    logic rx_is_ctrl = 1'b0;
    logic mf_boundary = 1'b0;
    logic sync_n;
    logic ilas_active;
    logic data_valid;
    logic [7:0] data_out;
    logic cfg_valid;
    logic [CFGN*8-1:0] cfg_bank;
    logic align_err;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    lane_link_rx u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_octet    (rx_octet),
        .rx_is_ctrl  (rx_is_ctrl),
        .mf_boundary (mf_boundary),
        .sync_n      (sync_n),
        .ilas_active (ilas_active),
        .data_valid  (data_valid),
        .data_out    (data_out),
        .cfg_valid   (cfg_valid),
        .cfg_bank    (cfg_bank),
        .align_err   (align_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] o, input logic k, input logic b);
        @(negedge clk);
        rx_octet = o;
        rx_is_ctrl = k;
        mf_boundary = b;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rx_octet = 8'h00;
        rx_is_ctrl = 1'b0;
        mf_boundary = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic lock();
        for (int i = 0; i < 4; i++) send(8'hBC, 1'b1, 1'b0);
    endtask

    // One alignment multiframe; bad_q/bad_a corrupt the marker positions.
    task automatic send_mf(input int m, input bit bad_q, input bit bad_a);
        for (int p = 0; p < MF; p++) begin
            if (p == 0) send(8'h1C, 1'b1, 1'b1);
            else if (p == MF - 1) send(bad_a ? 8'h7C : 8'h7C, !bad_a, 1'b0);
            else if (m == 1 && p == 1) send(8'h9C, !bad_q, 1'b0);
            else if (m == 1) send(8'hA0 + 8'(p - 2), 1'b0, 1'b0);
            else send(8'h10 + 8'(p), 1'b0, 1'b0);
        end
    endtask

    task automatic t_reset();
        do_reset();
        @(posedge clk);
        #1;
        chk("R1 sync_n", sync_n, 0);
        chk("R1 ilas_active", ilas_active, 0);
        chk("R1 data_valid", data_valid, 0);
        chk("R1 cfg_valid", cfg_valid, 0);
        chk("R1 align_err", align_err, 0);
    endtask

    task automatic t_cgs_restart();
        do_reset();
        for (int i = 0; i < 3; i++) send(8'hBC, 1'b1, 1'b0);
        send(8'hBC, 1'b0, 1'b0);
        chk("R2 data byte 0xBC not a sync char", sync_n, 0);
        for (int i = 0; i < 3; i++) send(8'hBC, 1'b1, 1'b0);
        chk("R4 restarted count holds request", sync_n, 0);
        send(8'hBC, 1'b1, 1'b0);
        chk("R3 release on fourth sync char", sync_n, 1);
    endtask

    task automatic t_full_sequence();
        int early = 0;
        do_reset();
        lock();
        send(8'hBC, 1'b1, 1'b0);
        chk("R5 sync char keeps waiting", {sync_n, ilas_active}, 2'b10);
        send_mf(0, 1'b0, 1'b0);
        chk("R5 sequence running", ilas_active, 1);
        send_mf(1, 1'b0, 1'b0);
        chk("R6 cfg_valid", cfg_valid, 1);
        chk("R6 cfg_bank", cfg_bank, 40'hA4A3A2A1A0);
        send_mf(2, 1'b0, 1'b0);
        for (int p = 0; p < MF; p++) begin
            if (p == 0) send(8'h1C, 1'b1, 1'b1);
            else if (p == MF - 1) send(8'h7C, 1'b1, 1'b0);
            else send(8'h30, 1'b0, 1'b0);
            if (data_valid !== 1'b0) early++;
        end
        chk("R9 no data during sequence", early, 0);
        chk("R9 sequence finished", ilas_active, 0);
        send(8'h5A, 1'b0, 1'b0);
        chk("R9 first data", {data_valid, data_out}, {1'b1, 8'h5A});
        send(8'h3C, 1'b0, 1'b0);
        chk("R9 second data", {data_valid, data_out}, {1'b1, 8'h3C});
        chk("R6 cfg kept", cfg_bank, 40'hA4A3A2A1A0);
    endtask

    task automatic t_bad_end();
        do_reset();
        lock();
        send_mf(0, 1'b0, 1'b1);
        chk("R8 missing end marker", {align_err, sync_n, ilas_active}, 3'b100);
        lock();
        chk("R10 error cleared on relock", {align_err, sync_n}, 2'b01);
    endtask

    task automatic t_bad_cfg_marker();
        do_reset();
        lock();
        send_mf(0, 1'b0, 1'b0);
        send(8'h1C, 1'b1, 1'b1);
        send(8'h9C, 1'b0, 1'b0);
        chk("R7 missing config marker", {align_err, sync_n, cfg_valid}, 3'b100);
    endtask

    task automatic t_bad_start();
        do_reset();
        lock();
        send(8'h1C, 1'b1, 1'b0);
        chk("R5 start off boundary", {align_err, sync_n, ilas_active}, 3'b100);
        lock();
        send(8'h44, 1'b0, 1'b0);
        chk("R5 stray octet while waiting", {align_err, sync_n}, 2'b10);
    endtask

    initial begin
        t_reset();
        t_cgs_restart();
        t_full_sequence();
        t_bad_end();
        t_bad_cfg_marker();
        t_bad_start();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule